// File: doc/BRIEF.md
# Power Mode Clock Controller

This block holds the power mode of a small processor subsystem and derives from it the enables that gate each group of units, a core-rate clock enable, and the enable of the system PLL. Software selects a mode and a gear divisor by writing a control word. It can also set the timeout that bounds the wait for PLL relock. Writes are accepted only while the subsystem runs in one of the two normal modes. In any other state the block reports itself busy and drops the write.

Seven modes are kept, from most to least power: normal-high, normal-low, doze-high, doze-low, sleep, deep sleep and power down. The low variants pace the live units with a divided clock-enable pulse set by the gear field. Any wake event in a low-power mode returns the block to a normal mode:
- From doze, the return takes one cycle.
- From sleep, a fixed four-cycle wake phase runs with the PLL still on.
- From deep sleep or power down, the PLL enable is raised first, and the block waits until the lock input rises or the programmed timeout expires.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset the mode is normal-high (code 0), `stat_busy` is 0, `unit_en` is 6'h3F, `pll_en` is 1, the gear code is 0 so `core_ce` is high every cycle, and the lock timeout holds TMO_RST.
- R2: `unit_en` bits are [0] core, [1] time base/decrementer, [2] memory controller, [3] real-time clock, [4] periodic timer and [5] communications processor. Normal modes enable all six. Doze enables bits 1-3 and raises `cpm_stby`. Sleep and deep sleep enable bits 3 and 4. Power down enables none. Any wake phase enables bits 3 and 4.
- R3: In normal-high and doze-high, `core_ce` is high every cycle. In normal-low and doze-low it is a one-cycle pulse every 2^g cycles, where g is the gear code clamped to 4. It is low in sleep, deep sleep, power down and every wake phase.
- R4: A new gear code takes effect only after the `core_ce` pulse that ends the divide period in progress. No period is shortened or cut.
- R5: A write with `wr_addr`=0 sets the gear code from `wr_data[5:3]` and the mode from `wr_data[2:0]`, using codes 0 normal-high, 1 normal-low, 2 doze-high, 3 doze-low, 4 sleep, 5 deep sleep and 6 power down. A mode code of 7 leaves the mode unchanged but still writes the gear code.
- R6: `stat_busy` is 1 outside the two normal modes and throughout wake phases. While busy, writes to either address are ignored. `stat_mode` shows the current mode and, during a wake phase, the mode being left.
- R7: A wake event in doze-high or doze-low gives normal-high or normal-low, respectively, on the next cycle.
- R8: A wake event in sleep starts a wake phase of exactly 4 cycles with `pll_en` high, after which the mode is normal-high.
- R9: A wake event in deep sleep or power down starts a wake phase with `pll_en` high. The phase ends on the clock edge where `pll_lock` is seen high or where its cycle count equals the timeout, so with no lock it lasts timeout+1 cycles. The mode then becomes normal-high. The timeout is written with `wr_addr`=1 from `wr_data[7:0]`.
- R10: Wake events have no effect in the normal modes or during a wake phase.
- R11: `pll_en` is low exactly in deep sleep and power down outside a wake phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = mode/gear word, 1 = lock timeout |
| wr_data | input | DW (8) | Write data |
| wake_evt | input | WAKE_N (3) | Wake event lines (timer, periodic, external) |
| pll_lock | input | 1 | PLL lock indication |
| core_ce | output | 1 | Core-rate clock enable pulse |
| unit_en | output | 6 | Per-group clock enables |
| cpm_stby | output | 1 | Communications processor standby request |
| pll_en | output | 1 | PLL enable |
| stat_mode | output | 3 | Current mode code |
| stat_busy | output | 1 | Not in a normal mode; writes ignored |

## Verification
The bench changes the gear code partway through a divide-by-16 period. A design that reloads at once would pulse early and cut the period short. It writes a mode and a timeout while in doze. If those writes leaked through, the later deep-sleep wake would last the wrong number of cycles. It raises a second wake event inside the sleep wake phase, which would restart or shorten a four-cycle count that was handled wrongly. It also checks both exits from the PLL wait, by timeout and by lock. A design with an off-by-one in the timeout compare, or one that ignores lock, would return to normal one cycle off or too late.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int TMO_W    = 8,
  parameter int TMO_RST  = 32,
  parameter int GEAR_MAX = 4,
  parameter int FAST_CYC = 4,
  parameter int WAKE_N   = 3,
  localparam int DW      = (TMO_W > 6) ? TMO_W : 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [WAKE_N-1:0] wake_evt,
  input  logic              pll_lock,
  output logic              core_ce,
  output logic [5:0]        unit_en,
  output logic              cpm_stby,
  output logic              pll_en,
  output logic [2:0]        stat_mode,
  output logic              stat_busy
);
  localparam int CNT_W = (GEAR_MAX > 0) ? GEAR_MAX : 1;
  localparam int SH_W  = $clog2(GEAR_MAX + 1) > 0 ? $clog2(GEAR_MAX + 1) : 1;
  localparam logic [TMO_W-1:0] FAST_LAST = TMO_W'(FAST_CYC - 1);

  localparam logic [2:0] M_NH = 3'd0, M_NL = 3'd1, M_DH = 3'd2, M_DL = 3'd3,
                         M_SL = 3'd4, M_DS = 3'd5, M_PD = 3'd6, M_BAD = 3'd7;
  localparam logic [1:0] W_IDLE = 2'd0, W_FAST = 2'd1, W_PLL = 2'd2;

  logic [2:0]       mode_q;
  logic [1:0]       wph_q;
  logic [TMO_W-1:0] wcnt_q, tmo_q;
  logic [2:0]       gear_q;
  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] div_q;

  wire in_wake  = (wph_q != W_IDLE);
  wire is_norm  = !in_wake && (mode_q == M_NH || mode_q == M_NL);
  wire wr_ok    = wr_en && is_norm;
  wire any_wake = |wake_evt;
  wire run_hi   = !in_wake && (mode_q == M_NH || mode_q == M_DH);
  wire run_lo   = !in_wake && (mode_q == M_NL || mode_q == M_DL);

  wire [SH_W-1:0]  gear_eff = (int'(gear_q) > GEAR_MAX) ? SH_W'(GEAR_MAX) : SH_W'(gear_q);
  wire [CNT_W-1:0] div_last = CNT_W'((32'd1 << sh_q) - 32'd1);
  wire             div_end  = (div_q == div_last);

  assign core_ce   = run_hi || (run_lo && div_end);
  assign pll_en    = in_wake || !(mode_q == M_DS || mode_q == M_PD);
  assign cpm_stby  = !in_wake && (mode_q == M_DH || mode_q == M_DL);
  assign stat_mode = mode_q;
  assign stat_busy = !is_norm;

  always_comb begin
    if (in_wake) unit_en = 6'b011000;
    else begin
      case (mode_q)
        M_NH, M_NL: unit_en = 6'b111111;
        M_DH, M_DL: unit_en = 6'b001110;
        M_SL, M_DS: unit_en = 6'b011000;
        default:    unit_en = 6'b000000;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sh_q  <= '0;
    end else if (run_lo) begin
      if (div_end) begin
        div_q <= '0;
        sh_q  <= gear_eff;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end else begin
      div_q <= '0;
      sh_q  <= gear_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_NH;
      wph_q  <= W_IDLE;
      wcnt_q <= '0;
      gear_q <= '0;
      tmo_q  <= TMO_W'(TMO_RST);
    end else begin
      if (wr_ok && !wr_addr) begin
        gear_q <= wr_data[5:3];
        if (wr_data[2:0] != M_BAD) mode_q <= wr_data[2:0];
      end
      if (wr_ok && wr_addr) tmo_q <= wr_data[TMO_W-1:0];
      case (wph_q)
        W_IDLE: if (any_wake) begin
          case (mode_q)
            M_DH: mode_q <= M_NH;
            M_DL: mode_q <= M_NL;
            M_SL: begin wph_q <= W_FAST; wcnt_q <= '0; end
            M_DS, M_PD: begin wph_q <= W_PLL; wcnt_q <= '0; end
            default: ;
          endcase
        end
        W_FAST: begin
          if (wcnt_q == FAST_LAST) begin
            wph_q  <= W_IDLE;
            mode_q <= M_NH;
          end else wcnt_q <= wcnt_q + 1'b1;
        end
        W_PLL: begin
          if (pll_lock || wcnt_q == tmo_q) begin
            wph_q  <= W_IDLE;
            mode_q <= M_NH;
          end else wcnt_q <= wcnt_q + 1'b1;
        end
        default: wph_q <= W_IDLE;
      endcase
    end
  end

  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_busy && wr_en) |=> ($stable(gear_q) && $stable(tmo_q)));

  p_mode_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != M_BAD);

  p_gear_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_lo && !core_ce) |=> $stable(sh_q));

  p_lowpwr_noce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wake || mode_q == M_SL || mode_q == M_DS || mode_q == M_PD) |-> !core_ce);

  p_doze_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_wake && mode_q == M_DL && any_wake) |=> (mode_q == M_NL && !stat_busy));

  p_sleep_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wph_q == W_FAST && wcnt_q == FAST_LAST) |=> (mode_q == M_NH && !stat_busy));

  p_lock_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wph_q == W_PLL && pll_lock) |=> (mode_q == M_NH && !stat_busy && pll_en));

  p_norm_ignore_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_norm && !(wr_en && !wr_addr)) |=> ($stable(mode_q) && !stat_busy));

  p_wake_pll_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_wake) && in_wake) |-> pll_en);
endmodule

// File: tb/tb_pwr_mode_ctl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [2:0] wake_evt = 3'd0;
  logic       pll_lock = 1'b0;
  logic       core_ce, cpm_stby, pll_en, stat_busy;
  logic [5:0] unit_en;
  logic [2:0] stat_mode;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wake_evt(wake_evt), .pll_lock(pll_lock), .core_ce(core_ce), .unit_en(unit_en),
    .cpm_stby(cpm_stby), .pll_en(pll_en), .stat_mode(stat_mode), .stat_busy(stat_busy)
  );

  // behavioural reference: mode, wake phase (0 none,1 sleep,2 pll), counters
  int m_mode, m_ph, m_wc, m_gear, m_tmo, m_div, m_sh;
  bit m_norm;

  function automatic int clamp_g(int g);
    return (g > 4) ? 4 : g;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_ph = 0; m_wc = 0; m_gear = 0; m_tmo = 32; m_div = 0; m_sh = 0;
    end else begin
      m_norm = (m_ph == 0) && (m_mode <= 1);
      if (m_ph == 0 && (m_mode == 1 || m_mode == 3)) begin
        if (m_div == (1 << m_sh) - 1) begin m_div = 0; m_sh = clamp_g(m_gear); end
        else m_div++;
      end else begin
        m_div = 0; m_sh = clamp_g(m_gear);
      end
      if (m_ph == 1) begin
        if (m_wc == 3) begin m_ph = 0; m_mode = 0; end else m_wc++;
      end else if (m_ph == 2) begin
        if (pll_lock || m_wc == m_tmo) begin m_ph = 0; m_mode = 0; end else m_wc++;
      end else if (wake_evt != 0) begin
        if (m_mode == 2) m_mode = 0;
        else if (m_mode == 3) m_mode = 1;
        else if (m_mode == 4) begin m_ph = 1; m_wc = 0; end
        else if (m_mode >= 5) begin m_ph = 2; m_wc = 0; end
      end
      if (m_norm && wr_en) begin
        if (!wr_addr) begin
          m_gear = int'(wr_data[5:3]);
          if (wr_data[2:0] != 3'd7) m_mode = int'(wr_data[2:0]);
        end else m_tmo = int'(wr_data);
      end
    end
  end

  function automatic int e_units();
    if (m_ph != 0) return 'h18;
    case (m_mode)
      0, 1: return 'h3F;
      2, 3: return 'h0E;
      4, 5: return 'h18;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e_ce, e_pll, e_busy, e_stby;
      bit bad;
      string tg;
      e_ce   = ((m_ph == 0 && (m_mode == 0 || m_mode == 2)) ||
                (m_ph == 0 && (m_mode == 1 || m_mode == 3) && m_div == (1 << m_sh) - 1)) ? 1 : 0;
      e_pll  = (m_ph != 0 || m_mode < 5) ? 1 : 0;
      e_busy = (m_ph == 0 && m_mode <= 1) ? 0 : 1;
      e_stby = (m_ph == 0 && (m_mode == 2 || m_mode == 3)) ? 1 : 0;
      tg = (m_ph == 1) ? "R8" : (m_ph == 2) ? "R9" : "R6";
      bad = 0;
      compared++;
      if (int'(core_ce) != e_ce) begin
        bad = 1; $display("FAIL R3 core_ce act=%0d exp=%0d t=%0t", core_ce, e_ce, $time);
      end
      if (int'(unit_en) != e_units()) begin
        bad = 1; $display("FAIL R2 unit_en act=%0h exp=%0h t=%0t", unit_en, e_units(), $time);
      end
      if (int'(cpm_stby) != e_stby) begin
        bad = 1; $display("FAIL R2 cpm_stby act=%0d exp=%0d t=%0t", cpm_stby, e_stby, $time);
      end
      if (int'(pll_en) != e_pll) begin
        bad = 1; $display("FAIL R11 pll_en act=%0d exp=%0d t=%0t", pll_en, e_pll, $time);
      end
      if (int'(stat_busy) != e_busy) begin
        bad = 1; $display("FAIL %s stat_busy act=%0d exp=%0d t=%0t", tg, stat_busy, e_busy, $time);
      end
      if (int'(stat_mode) != m_mode) begin
        bad = 1; $display("FAIL %s stat_mode act=%0d exp=%0d t=%0t", tg, stat_mode, m_mode, $time);
      end
      if (bad) mismatched++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'd0;
  endtask

  task automatic wake(input int bits);
    @(negedge clk);
    wake_evt = 3'(bits);
    @(negedge clk);
    wake_evt = 3'd0;
  endtask

  task automatic count_ce(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (core_ce) c++;
      @(negedge clk);
    end
  endtask

  initial begin
    int c, n;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    // R1 reset state
    chk("R1 mode", stat_mode, 0);
    chk("R1 busy", stat_busy, 0);
    chk("R1 units", unit_en, 'h3F);
    chk("R1 pll", pll_en, 1);
    chk("R1 ce", core_ce, 1);

    // R3 normal-low, gear 2 -> divide by 4
    wr(0, (2 << 3) | 1);
    count_ce(40, c);
    chk("R3 div4 pulses", c, 10);
    // R3 gear 7 clamps to divide by 16
    wr(0, (7 << 3) | 1);
    idle(8);
    count_ce(64, c);
    chk("R3 div16 pulses", c, 4);

    // R4 gear change mid-period waits for the period end
    n = 0;
    while (!core_ce && n < 40) begin @(negedge clk); n++; end
    idle(3);
    wr(0, 1);
    n = 0;
    while (!core_ce && n < 40) begin @(negedge clk); n++; end
    chk("R4 low samples before pulse", n, 11);
    @(negedge clk);
    chk("R4 new divisor active", core_ce, 1);

    // R5 mode code 7 keeps mode, writes gear 3
    wr(0, (3 << 3) | 7);
    chk("R5 mode kept", stat_mode, 1);
    idle(2);
    count_ce(32, c);
    chk("R5 gear written", c, 4);

    wr(1, 5);

    // R2/R3 doze-low gear 1
    wr(0, (1 << 3) | 3);
    chk("R2 doze units", unit_en, 'h0E);
    chk("R6 doze busy", stat_busy, 1);
    idle(10);
    count_ce(20, c);
    chk("R3 doze-low pulses", c, 10);
    // R6 writes ignored while busy
    wr(0, 0);
    wr(1, 200);
    chk("R6 mode unchanged", stat_mode, 3);
    // R7 doze-low wake
    wake(1);
    chk("R7 back to normal-low", stat_mode, 1);
    chk("R7 not busy", stat_busy, 0);
    wr(0, 2);
    wake(4);
    chk("R7 back to normal-high", stat_mode, 0);

    // R8 sleep wake, with extra wake ignored (R10)
    wr(0, 4);
    chk("R2 sleep units", unit_en, 'h18);
    chk("R11 sleep pll", pll_en, 1);
    idle(3);
    wake(2);
    chk("R8 wake busy", stat_busy, 1);
    wake(1);
    idle(1);
    chk("R8 still waking", stat_busy, 1);
    idle(1);
    chk("R8 normal after 4", stat_busy, 0);
    chk("R10 mode normal-high", stat_mode, 0);

    // R9 deep sleep wake by timeout (5 -> 6 cycles)
    wr(0, 5);
    chk("R11 deep pll off", pll_en, 0);
    idle(4);
    wake(1);
    chk("R9 pll raised", pll_en, 1);
    n = 0;
    while (stat_busy && n < 300) begin @(negedge clk); n++; end
    chk("R9 timeout cycles", n, 6);

    // R9 power down wake by lock
    wr(0, 6);
    chk("R2 pdown units", unit_en, 0);
    chk("R11 pdown pll off", pll_en, 0);
    idle(2);
    wake(4);
    @(negedge clk);
    pll_lock = 1'b1;
    @(negedge clk);
    pll_lock = 1'b0;
    chk("R9 lock exit busy", stat_busy, 0);
    chk("R9 lock exit mode", stat_mode, 0);

    // R10 wake in normal ignored
    wake(7);
    chk("R10 normal ignores wake", stat_mode, 0);
    chk("R10 not busy", stat_busy, 0);

    // R1 reset from sleep
    wr(0, (4 << 3) | 4);
    idle(2);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    chk("R1 reset mode", stat_mode, 0);
    chk("R1 reset ce", core_ce, 1);
    chk("R1 reset units", unit_en, 'h3F);
    idle(4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired t=%0t", $time);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule